// File: doc/BRIEF.md
# Serial port status flag unit

This block holds the status flags of an asynchronous serial port that can tag frames with a multiprocessor (address/data) bit. An external shift engine reports three kinds of event as single-cycle strobes: a frame arrived, with or without a parity mismatch; the transmit data register was taken into the shifter; and the last bit of a character left the line. From these strobes the block maintains six fields: transmit-empty, receive-full, parity-error, transmit-end, the received multiprocessor bit and the multiprocessor bit to send. It also holds the receive and transmit data registers.

Software reaches the block through a small register port. Address 0 is the status register, address 1 returns the received word, and address 2 reads or writes the transmit word. A DMA write strobe can also load the transmit word. The error and empty/full flags are protected against accidental clearing. A flag clears only when a 0 is written to it after a status read that returned it as 1. A parity error freezes reception until software acknowledges it. In clocked synchronous mode it also raises a transmit halt.

Top module: `serial_flag_unit`

## Requirements
- R1: After reset the status register reads 0x09: transmit-empty (bit 0) is 1, receive-full (bit 1) is 0, parity-error (bit 2) is 0, transmit-end (bit 3) is 1, the received multiprocessor bit (bit 4) is 0 and the transmit multiprocessor bit (bit 5) is 0. Bits 7:6 read 0. `rx_halt`, `tx_halt` and `tx_mpb` are 0.
- R2: When a frame strobe arrives with `rx_en`=1, parity-error=0 and no parity mismatch, then on the next cycle the received word (address 1) equals `rx_word`, bit 4 equals `rx_mpb` and receive-full is 1.
- R3: A frame with a parity mismatch in asynchronous mode (`sync_mode`=0) still loads the received word and bit 4. It sets parity-error and leaves receive-full unchanged. In synchronous mode the mismatch strobe is ignored and the frame counts as good.
- R4: While parity-error is 1, `rx_halt` is 1 and frame strobes change neither the received word, bit 4 nor receive-full. `tx_halt` is 1 only while parity-error is 1 and `sync_mode` is 1.
- R5: Bits 0, 1 and 2 clear only on a status write of 0 to that bit that comes after a status read that returned the bit as 1. Writing 1, or writing 0 without such a read, leaves the bit unchanged. Every status write disarms all three bits.
- R6: While `rx_en` is 0, frame strobes are ignored, and parity-error and bit 4 keep their values.
- R7: Transmit-end becomes 1 on the cycle after `tx_en` is 0. It also becomes 1 after a `tx_last` strobe that arrives while transmit-empty is 1. A `tx_last` strobe while transmit-empty is 0 leaves it unchanged.
- R8: Transmit-end clears with an armed write of 0 to bit 0. It also clears on a `dma_wr` strobe, which in the same cycle clears transmit-empty and loads `dma_data` into the transmit word (address 2).
- R9: When a set event and a clearing event for the same flag fall in the same cycle, the flag ends up 1.
- R10: Bit 5 is written from status writes and drives `tx_mpb`. Bits 3 and 4 ignore status writes.
- R11: A `tx_load` strobe sets transmit-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| sync_mode | input | 1 | 1 selects clocked synchronous mode |
| rx_done | input | 1 | Frame-received strobe |
| rx_par_err | input | 1 | Parity mismatch on the strobed frame |
| rx_word | input | DW | Received data word |
| rx_mpb | input | 1 | Received multiprocessor bit |
| tx_load | input | 1 | Transmit word taken by the shifter |
| tx_last | input | 1 | Last bit of a character shifted out |
| dma_wr | input | 1 | DMA write to the transmit word |
| dma_data | input | DW | DMA write data |
| reg_addr | input | 2 | Register select: 0 status, 1 receive word, 2 transmit word |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| tx_word | output | DW | Transmit word to the shifter |
| tx_mpb | output | 1 | Multiprocessor bit to send |
| rx_halt | output | 1 | Reception halted by a parity error |
| tx_halt | output | 1 | Transmission halted (synchronous mode) |
| flag_txe | output | 1 | Transmit-empty |
| flag_rxf | output | 1 | Receive-full |
| flag_perr | output | 1 | Parity-error |
| flag_tend | output | 1 | Transmit-end |
| flag_mpb | output | 1 | Received multiprocessor bit |

## Verification
The bench sweeps all 256 received words, then tests the read-before-clear rule. A write of 0 with no prior read must leave each flag set; a design that skips the arming would clear it. A write of 1 after a read must also leave the flag set; a design that toggles or copies the written value would drop it. It tests parity errors in both modes. A design that raised receive-full on a bad frame, kept accepting frames while halted, or dropped the error when the receiver was disabled would show a wrong receive word or wrong status. It also makes set and clear events collide in one cycle, for transmit-empty, receive-full and transmit-end. A design that let the clear win would read 0 where 1 is expected.

// File: rtl/serial_flag_unit.sv
module serial_flag_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          sync_mode,
  input  logic          rx_done,
  input  logic          rx_par_err,
  input  logic [DW-1:0] rx_word,
  input  logic          rx_mpb,
  input  logic          tx_load,
  input  logic          tx_last,
  input  logic          dma_wr,
  input  logic [DW-1:0] dma_data,
  input  logic [1:0]    reg_addr,
  input  logic          reg_rd,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] tx_word,
  output logic          tx_mpb,
  output logic          rx_halt,
  output logic          tx_halt,
  output logic          flag_txe,
  output logic          flag_rxf,
  output logic          flag_perr,
  output logic          flag_tend,
  output logic          flag_mpb
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_RXD  = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam int B_TXE = 0, B_RXF = 1, B_PERR = 2, B_TEND = 3, B_MPB = 4, B_MPBT = 5;

  logic txe, rxf, perr, tend, mpb, mpbt;
  logic arm_txe, arm_rxf, arm_perr;
  logic [DW-1:0] rdr, tdr;
  logic [DW-1:0] status;

  wire stat_wr  = reg_wr & (reg_addr == A_STAT);
  wire stat_rd  = reg_rd & (reg_addr == A_STAT);
  wire clr_txe  = stat_wr & arm_txe  & ~reg_wdata[B_TXE];
  wire clr_rxf  = stat_wr & arm_rxf  & ~reg_wdata[B_RXF];
  wire clr_perr = stat_wr & arm_perr & ~reg_wdata[B_PERR];
  wire rx_take  = rx_done & rx_en & ~perr;
  wire rx_bad   = rx_take & rx_par_err & ~sync_mode;
  wire rx_good  = rx_take & ~rx_bad;
  wire tend_set = ~tx_en | (tx_last & txe);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe  <= 1'b1;
      rxf  <= 1'b0;
      perr <= 1'b0;
      tend <= 1'b1;
      mpb  <= 1'b0;
      mpbt <= 1'b0;
      rdr  <= '0;
      tdr  <= '0;
    end else begin
      if (tx_load)                txe <= 1'b1;
      else if (clr_txe | dma_wr)  txe <= 1'b0;
      if (tend_set)               tend <= 1'b1;
      else if (clr_txe | dma_wr)  tend <= 1'b0;
      if (rx_good)                rxf <= 1'b1;
      else if (clr_rxf)           rxf <= 1'b0;
      if (rx_bad)                 perr <= 1'b1;
      else if (clr_perr)          perr <= 1'b0;
      if (rx_take) begin
        rdr <= rx_word;
        mpb <= rx_mpb;
      end
      if (stat_wr) mpbt <= reg_wdata[B_MPBT];
      if (dma_wr)                             tdr <= dma_data;
      else if (reg_wr && reg_addr == A_TXD)   tdr <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_txe  <= 1'b0;
      arm_rxf  <= 1'b0;
      arm_perr <= 1'b0;
    end else if (stat_wr) begin
      arm_txe  <= 1'b0;
      arm_rxf  <= 1'b0;
      arm_perr <= 1'b0;
    end else if (stat_rd) begin
      arm_txe  <= txe;
      arm_rxf  <= rxf;
      arm_perr <= perr;
    end
  end

  always_comb begin
    status         = '0;
    status[B_TXE]  = txe;
    status[B_RXF]  = rxf;
    status[B_PERR] = perr;
    status[B_TEND] = tend;
    status[B_MPB]  = mpb;
    status[B_MPBT] = mpbt;
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status;
      A_RXD:   reg_rdata = rdr;
      A_TXD:   reg_rdata = tdr;
      default: reg_rdata = '0;
    endcase
  end

  assign tx_word   = tdr;
  assign tx_mpb    = mpbt;
  assign rx_halt   = perr;
  assign tx_halt   = perr & sync_mode;
  assign flag_txe  = txe;
  assign flag_rxf  = rxf;
  assign flag_perr = perr;
  assign flag_tend = tend;
  assign flag_mpb  = mpb;

  // R4
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_perr |=> ($stable(rdr) && (flag_rxf == $past(flag_rxf))));
  // R3
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && !flag_perr && rx_par_err && !sync_mode)
      |=> (flag_perr && flag_rxf == $past(flag_rxf) && rdr == $past(rx_word)));
  // R7
  tend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> flag_tend);
  // R5
  perr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_perr && !stat_wr) |=> flag_perr);
  // R8
  tend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_tend && !stat_wr && !dma_wr) |=> flag_tend);
  // R10
  mpbt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(tx_mpb));
  // R6
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> ($stable(flag_mpb) && $stable(rdr)));
endmodule

// File: tb/serial_flag_unit_bench.sv
module serial_flag_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, tx_en = 0, sync_mode = 0;
  logic rx_done = 0, rx_par_err = 0, rx_mpb = 0;
  logic [DW-1:0] rx_word = '0;
  logic tx_load = 0, tx_last = 0, dma_wr = 0;
  logic [DW-1:0] dma_data = '0;
  logic [1:0] reg_addr = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata, tx_word;
  logic tx_mpb, rx_halt, tx_halt;
  logic flag_txe, flag_rxf, flag_perr, flag_tend, flag_mpb;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_flag_unit #(.DW(DW)) u_serial_flag_unit (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en), .sync_mode(sync_mode),
    .rx_done(rx_done), .rx_par_err(rx_par_err), .rx_word(rx_word), .rx_mpb(rx_mpb),
    .tx_load(tx_load), .tx_last(tx_last), .dma_wr(dma_wr), .dma_data(dma_data),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_word(tx_word), .tx_mpb(tx_mpb), .rx_halt(rx_halt),
    .tx_halt(tx_halt), .flag_txe(flag_txe), .flag_rxf(flag_rxf), .flag_perr(flag_perr),
    .flag_tend(flag_tend), .flag_mpb(flag_mpb));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic chk_stat(string req, int exp);
    logic [DW-1:0] v;
    peek(0, v);
    check(req, v, exp);
  endtask

  task automatic rd_stat();
    reg_addr = 0; reg_rd = 1; step(); reg_rd = 0;
  endtask

  task automatic wr_stat_set(input logic [DW-1:0] v);
    reg_addr = 0; reg_wdata = v; reg_wr = 1;
  endtask

  task automatic frame_set(input logic [DW-1:0] d, input logic m, input logic pe);
    rx_word = d; rx_mpb = m; rx_par_err = pe; rx_done = 1;
  endtask

  task automatic clear_strobes();
    rx_done = 0; rx_par_err = 0; reg_wr = 0; reg_rd = 0;
    tx_load = 0; tx_last = 0; dma_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) step();
    rst_n = 1; step();
    chk_stat("R1", 8'h09);
    check("R1 rx_halt", rx_halt, 0);
    check("R1 tx_halt", tx_halt, 0);
    check("R1 tx_mpb", tx_mpb, 0);

    tx_en = 1; rx_en = 1; step();
    for (int i = 0; i < 256; i++) begin
      frame_set(i[DW-1:0], i[0], 0); step(); clear_strobes();
      peek(1, v);
      check("R2 word", v, i);
      check("R2 mpb", flag_mpb, i & 1);
      check("R2 rxf", flag_rxf, 1);
    end
    chk_stat("R2", 8'h1B);

    wr_stat_set(8'hDD); step(); clear_strobes();
    chk_stat("R5 no read", 8'h1B);
    rd_stat(); wr_stat_set(8'hFF); step(); clear_strobes();
    chk_stat("R5 write one", 8'h3B);
    check("R10 tx_mpb", tx_mpb, 1);
    wr_stat_set(8'hE7); step(); clear_strobes();
    chk_stat("R10 ro bits", 8'h3B);
    rd_stat(); wr_stat_set(8'hDD); step(); clear_strobes();
    chk_stat("R5 clear rxf", 8'h19);
    check("R10 tx_mpb off", tx_mpb, 0);

    frame_set(8'hA5, 0, 1); step(); clear_strobes();
    peek(1, v); check("R3 word", v, 8'hA5);
    chk_stat("R3 perr", 8'h0D);
    check("R4 rx_halt", rx_halt, 1);
    check("R4 tx_halt async", tx_halt, 0);
    frame_set(8'h3C, 1, 0); step(); clear_strobes();
    peek(1, v); check("R4 word held", v, 8'hA5);
    chk_stat("R4 status held", 8'h0D);
    sync_mode = 1; #1; check("R4 tx_halt sync", tx_halt, 1);
    sync_mode = 0;

    rx_en = 0; step(); step();
    chk_stat("R6 perr kept", 8'h0D);
    rd_stat(); wr_stat_set(8'hDB); step(); clear_strobes();
    chk_stat("R5 clear perr", 8'h09);
    check("R4 halt released", rx_halt, 0);
    frame_set(8'h77, 1, 0); step(); clear_strobes();
    peek(1, v); check("R6 word", v, 8'hA5);
    chk_stat("R6 status", 8'h09);
    rx_en = 1;

    sync_mode = 1;
    frame_set(8'h11, 1, 1); step(); clear_strobes();
    sync_mode = 0;
    chk_stat("R3 sync ignores parity", 8'h1B);
    peek(1, v); check("R3 sync word", v, 8'h11);

    rd_stat(); wr_stat_set(8'hDE); step(); clear_strobes();
    chk_stat("R8 clear tend", 8'h12);
    tx_last = 1; step(); clear_strobes();
    chk_stat("R7 last no txe", 8'h12);
    tx_load = 1; step(); clear_strobes();
    chk_stat("R11 load", 8'h13);
    tx_last = 1; step(); clear_strobes();
    chk_stat("R7 last with txe", 8'h1B);
    dma_data = 8'h5A; dma_wr = 1; step(); clear_strobes();
    chk_stat("R8 dma", 8'h12);
    peek(2, v); check("R8 dma word", v, 8'h5A);
    check("R8 tx_word", tx_word, 8'h5A);
    tx_en = 0; step(); tx_en = 1;
    chk_stat("R7 te off", 8'h1A);

    tx_load = 1; step(); clear_strobes();
    rd_stat(); wr_stat_set(8'hDE); tx_load = 1; step(); clear_strobes();
    chk_stat("R9 txe", 8'h13);
    rd_stat(); wr_stat_set(8'hDD); frame_set(8'h42, 0, 0); step(); clear_strobes();
    chk_stat("R9 rxf", 8'h03);
    peek(1, v); check("R9 word", v, 8'h42);
    rd_stat(); wr_stat_set(8'hDE); tx_en = 0; step(); clear_strobes(); tx_en = 1;
    chk_stat("R9 tend", 8'h0A);

    step();
    finish_run();
  end
endmodule